// File: doc/BRIEF.md
# Banked GPIO Controller with Edge-Detect Interrupts

This block controls a parameterised number of general-purpose pins, grouped into 32-bit banks. The last bank may be only partly populated. Software reaches it through a word-addressed register port that is always ready. Through that port it sets pin direction, reads the synchronised pin level, and drives the output latches. Outputs change through separate write-one-to-set and write-one-to-clear words, so software never needs a read-modify-write.

Each pin has a rising-edge enable and a falling-edge enable. An edge that is enabled sets a sticky status bit, and software clears that bit by writing a one to it. Pins 0 and 1 each drive a dedicated interrupt line. All other pins share one combined interrupt line.

A read request is answered on the next cycle, with a one-cycle `reg_rvalid` pulse. The register port has no back-pressure: every request is accepted in the cycle it is presented.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the direction, output, rising-enable, falling-enable and status words of every bank read 0. `pin_oe`, `pin_out` and all three interrupt lines are low.
- R2: The direction word (select 1) reads back what was written. A bit value of 1 makes the pin an output, so `pin_oe` for that pin equals the stored bit.
- R3: A write to the set word (select 2) forces high every output bit written as 1 and leaves bits written as 0 unchanged. Reads of select 2 or select 3 return the output latch, which also appears on `pin_out`.
- R4: A write to the clear word (select 3) forces low every output bit written as 1 and leaves bits written as 0 unchanged.
- R5: The level word (select 0) returns the pin inputs after a two-flop synchroniser, whatever the pin direction. A pin change is visible to a read issued 3 or more cycles later.
- R6: A pin whose rising-enable bit (select 4) is the only one set records rising transitions and ignores falling ones.
- R7: A pin whose falling-enable bit (select 5) is the only one set records falling transitions and ignores rising ones.
- R8: A pin with both enables set records either transition. A pin with neither enable set never sets its status bit.
- R9: Status bits (select 6) stay set until written with 1. Writing 0 to a bit has no effect, and writing all ones clears the whole bank.
- R10: When an enabled edge and a write-one-to-clear reach the same status bit in the same cycle, the bit remains set.
- R11: `irq_pin0` and `irq_pin1` follow the status bits of pins 0 and 1. `irq_shared` is the OR of the status bits of all other pins.
- R12: Bits above the last implemented pin read as 0, and writes to them are ignored. Select 7 always reads 0.
- R13: The word address is {select[2:0], bank index}, where the bank index is the low $clog2(banks) bits. A read produces `reg_rvalid` with its data exactly one cycle later, and a write produces no `reg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch per pin |
| pin_oe | output | NUM_PINS | Output enable (direction) per pin |
| reg_valid | input | 1 | Register request present |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address {select, bank} |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| irq_pin0 | output | 1 | Status of pin 0 |
| irq_pin1 | output | 1 | Status of pin 1 |
| irq_shared | output | 1 | OR of status of pins 2 and above |

## Verification
The assertions assume that only one register request arrives per cycle. They also assume that a set write and a clear write never target the same latch in the same cycle, which the single port guarantees. The assertions on edge-driven status changes further assume that pin inputs hold steady long enough for the synchroniser to settle. The stimulus changes pins only on the falling clock edge and then waits several cycles before it checks anything. The one exception is the collision case, where a clear write is timed on purpose to land in the cycle in which the falling edge is recognised.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_SET   = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_RISE  = 3'd4,
    SEL_FALL  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] lvl_prev,
  input  logic         we_dir,
  input  logic         we_set,
  input  logic         we_clr,
  input  logic         we_rise,
  input  logic         we_fall,
  input  logic         we_stat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] edge_hit;
  logic [W-1:0] stat_clr;
  logic [W-1:0] out_set;
  logic [W-1:0] out_clr;

  always_comb begin
    edge_hit = (lvl_now & ~lvl_prev & rise_q) | (~lvl_now & lvl_prev & fall_q);
    stat_clr = we_stat ? wdata : '0;
    out_set  = we_set  ? wdata : '0;
    out_clr  = we_clr  ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      if (we_dir)  dir_q  <= wdata;
      if (we_rise) rise_q <= wdata;
      if (we_fall) fall_q <= wdata;
      out_q  <= (out_q | out_set) & ~out_clr;
      stat_q <= (stat_q & ~stat_clr) | edge_hit;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q)) & ~$past(stat_clr)) == '0);

  assert_set_only_by_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ~$past(edge_hit)) == '0);

  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & stat_clr) != '0) |=> ((stat_q & $past(edge_hit & stat_clr)) == $past(edge_hit & stat_clr)));

  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_set != '0) |=> ((~out_q & $past(out_set)) == '0));

  assert_clr_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_clr != '0) |=> ((out_q & $past(out_clr)) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 81,
  parameter int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W,
  parameter int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int unsigned ADDR_W = SEL_W + BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic                reg_valid,
  input  logic                reg_write,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic                reg_rvalid,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared
);
  localparam int unsigned LAST_W = NUM_PINS - (NUM_BANKS - 1) * WORD_W;

  logic [NUM_PINS-1:0] lvl_now, lvl_prev, stat_all;
  logic [WORD_W-1:0]   w_lvl [NUM_BANKS];
  logic [WORD_W-1:0]   w_dir [NUM_BANKS];
  logic [WORD_W-1:0]   w_out [NUM_BANKS];
  logic [WORD_W-1:0]   w_rise[NUM_BANKS];
  logic [WORD_W-1:0]   w_fall[NUM_BANKS];
  logic [WORD_W-1:0]   w_stat[NUM_BANKS];
  reg_sel_e            sel;
  logic [BANK_W-1:0]   bank;
  logic                wr_go;
  logic [WORD_W-1:0]   rd_word;

  assign sel   = reg_sel_e'(reg_addr[ADDR_W-1 -: SEL_W]);
  assign bank  = reg_addr[BANK_W-1:0];
  assign wr_go = reg_valid && reg_write;

  gpio_input_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in),
    .sync_q(lvl_now), .prev_q(lvl_prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * WORD_W;
    localparam int unsigned BW = (b == NUM_BANKS - 1) ? LAST_W : WORD_W;
    logic          hit;
    logic [BW-1:0] dir_w, out_w, rise_w, fall_w, stat_w;

    assign hit = wr_go && (bank == BANK_W'(b));

    gpio_bank #(.W(BW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lvl_now(lvl_now[LO +: BW]), .lvl_prev(lvl_prev[LO +: BW]),
      .we_dir (hit && sel == SEL_DIR),
      .we_set (hit && sel == SEL_SET),
      .we_clr (hit && sel == SEL_CLR),
      .we_rise(hit && sel == SEL_RISE),
      .we_fall(hit && sel == SEL_FALL),
      .we_stat(hit && sel == SEL_STAT),
      .wdata(reg_wdata[BW-1:0]),
      .dir_q(dir_w), .out_q(out_w), .rise_q(rise_w), .fall_q(fall_w), .stat_q(stat_w)
    );

    assign pin_oe[LO +: BW]   = dir_w;
    assign pin_out[LO +: BW]  = out_w;
    assign stat_all[LO +: BW] = stat_w;
    assign w_lvl[b]  = WORD_W'(lvl_now[LO +: BW]);
    assign w_dir[b]  = WORD_W'(dir_w);
    assign w_out[b]  = WORD_W'(out_w);
    assign w_rise[b] = WORD_W'(rise_w);
    assign w_fall[b] = WORD_W'(fall_w);
    assign w_stat[b] = WORD_W'(stat_w);
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == BANK_W'(b)) begin
        case (sel)
          SEL_LEVEL:        rd_word = w_lvl[b];
          SEL_DIR:          rd_word = w_dir[b];
          SEL_SET, SEL_CLR: rd_word = w_out[b];
          SEL_RISE:         rd_word = w_rise[b];
          SEL_FALL:         rd_word = w_fall[b];
          SEL_STAT:         rd_word = w_stat[b];
          default:          rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_valid && !reg_write;
      if (reg_valid && !reg_write) reg_rdata <= rd_word;
    end
  end

  assign irq_pin0   = stat_all[0];
  assign irq_pin1   = stat_all[1];
  assign irq_shared = |stat_all[NUM_PINS-1:2];

  assert_read_answered_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> reg_rvalid);

  assert_no_spurious_rvalid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> !reg_rvalid);

  if (LAST_W < WORD_W) begin : g_pad_chk
    assert_pad_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write && bank == BANK_W'(NUM_BANKS - 1))
        |=> (reg_rdata[WORD_W-1:LAST_W] == '0));
  end
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  localparam int NP = 81;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          reg_valid = 1'b0, reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_rvalid;
  logic [31:0]   reg_rdata;
  logic          irq_pin0, irq_pin1, irq_shared;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
  );

  function automatic logic [AW-1:0] adr(input int sel, input int bank);
    return {3'(sel), 2'(bank)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic wr(input int sel, input int bank, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = adr(sel, bank); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input int sel, input int bank, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = adr(sel, bank);
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each returned read against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R13 actual=unexpected rvalid expected=none");
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(1, 0, 32'h0, "R1 dir");
    rd(4, 1, 32'h0, "R1 rise");
    rd(5, 2, 32'h0, "R1 fall");
    rd(6, 0, 32'h0, "R1 stat");
    rd(2, 1, 32'h0, "R1 out");
    chk("R1 irq", {29'd0, irq_pin0, irq_pin1, irq_shared}, 32'h0);
    chk("R1 oe", pin_oe[31:0], 32'h0);

    // R2 direction
    wr(1, 1, 32'hA5A5_0F0F);
    rd(1, 1, 32'hA5A5_0F0F, "R2 dir readback");
    chk("R2 pin_oe", pin_oe[63:32], 32'hA5A5_0F0F);

    // R3 set, R4 clear
    wr(2, 0, 32'h0000_00F0);
    rd(2, 0, 32'h0000_00F0, "R3 set");
    wr(2, 0, 32'h0000_0003);
    rd(3, 0, 32'h0000_00F3, "R3 set keeps zeros");
    wr(3, 0, 32'h0000_0030);
    rd(2, 0, 32'h0000_00C3, "R4 clear");
    chk("R4 pin_out", pin_out[31:0], 32'h0000_00C3);

    // R5 level
    pin_in[63:32] = 32'h1234_5678;
    pin_in[80] = 1'b1;
    idle(4);
    rd(0, 1, 32'h1234_5678, "R5 level bank1");
    rd(0, 2, 32'h0001_0000, "R5 level bank2");
    rd(0, 0, 32'h0, "R5 level bank0");

    // R6 R7 R8 edge enables: pin5 rise, pin6 fall, pin7 both, pin8 none
    wr(4, 0, 32'h0000_00A0);
    wr(5, 0, 32'h0000_00C0);
    pin_in[8:5] = 4'hF;
    idle(4);
    rd(6, 0, 32'h0000_00A0, "R6 R8 after rise");
    chk("R11 shared", {31'd0, irq_shared}, 32'h1);
    chk("R11 pin0 quiet", {31'd0, irq_pin0}, 32'h0);
    pin_in[8:5] = 4'h0;
    idle(4);
    rd(6, 0, 32'h0000_00E0, "R7 R8 after fall");

    // R9 write-one-to-clear
    wr(6, 0, 32'h0);
    rd(6, 0, 32'h0000_00E0, "R9 zero write");
    wr(6, 0, 32'h0000_0020);
    rd(6, 0, 32'h0000_00C0, "R9 single clear");
    wr(6, 0, 32'hFFFF_FFFF);
    rd(6, 0, 32'h0, "R9 clear all");
    chk("R11 shared low", {31'd0, irq_shared}, 32'h0);

    // R11 dedicated lines
    wr(4, 0, 32'h0000_00A3);
    pin_in[0] = 1'b1;
    idle(4);
    chk("R11 irq0", {29'd0, irq_pin0, irq_pin1, irq_shared}, 32'h4);
    pin_in[1] = 1'b1;
    idle(4);
    chk("R11 irq1", {29'd0, irq_pin0, irq_pin1, irq_shared}, 32'h6);
    wr(6, 0, 32'h0000_0001);
    chk("R11 irq0 cleared", {29'd0, irq_pin0, irq_pin1, irq_shared}, 32'h2);
    wr(6, 0, 32'hFFFF_FFFF);

    // R10 edge wins over clear
    pin_in[7] = 1'b1;
    idle(4);
    rd(6, 0, 32'h0000_0080, "R10 prior set");
    pin_in[7] = 1'b0;
    idle(2);
    wr(6, 0, 32'h0000_0080);
    rd(6, 0, 32'h0000_0080, "R10 edge beats clear");
    wr(6, 0, 32'h0000_0080);
    rd(6, 0, 32'h0, "R10 later clear");

    // R12 unimplemented bits
    wr(1, 2, 32'hFFFF_FFFF);
    rd(1, 2, 32'h0001_FFFF, "R12 dir pad");
    wr(2, 2, 32'hFFFF_FFFF);
    rd(3, 2, 32'h0001_FFFF, "R12 out pad");
    rd(7, 0, 32'h0, "R12 select7");

    // R13 no rvalid on write
    wr(4, 2, 32'h1);
    chk("R13 write no rvalid", {31'd0, reg_rvalid}, 32'h0);

    idle(3);
    chk("R13 scoreboard drained", exp_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule